// File: doc/BRIEF.md
# Macro-op group packer

The packer sits between an instruction pick stage and the execution back end. Each clock it looks at up to three already-classified instructions, offered in program order on parallel lanes. It emits one fixed-width group of three macro-operation slots. Each instruction's class tells the packer how many macro-operations it expands into. A single-class instruction yields one. A double-class instruction yields two. A sequenced instruction yields an explicit count of three or more.

Single and double instructions are packed densely. A double that finds only one free slot is split: its second macro-operation opens the next group, so three doubles fill exactly two groups. A sequenced instruction owns whole groups until its last macro-operation has left, issuing at most three per clock. Slots left over are padded with empty entries whose valid bit is low and whose fields are zero.

Every slot carries two opaque fields, an arithmetic-operation tag and an address-request tag, together with the position of that macro-operation inside its instruction. The output is a registered group with a valid/ready handshake. The input side reports how many lanes it consumed this clock, and the source shifts its window by that amount.

Top module: `mop_group_packer`

## Requirements
- R1: A synchronous active-high reset drops any partly issued instruction. It leaves out_valid low with every slot empty, and in_take is 0 while reset is high.
- R2: Class code 0 (and the reserved code 3) is a one-MOP instruction. Up to three of them are packed into one group, in lane order, starting at slot 0. Their index is 0.
- R3: Class code 1 is a two-MOP instruction placed in consecutive slots with index 0 then 1. When only one slot is free, index 0 takes it and index 1 leads the next group, so three such instructions fill exactly two groups.
- R4: Class code 2 is a sequenced instruction whose MOP count (3 to 15) comes from its count field. It emits indices 0 upward in order, at most three per group, over consecutive groups. Its MOPs never share a group with another instruction.
- R5: Instructions are placed strictly in program order. An instruction behind a sequenced one, or behind an incomplete split, waits until the earlier one has fully issued.
- R6: Valid slots always form a prefix starting at slot 0. Every unused slot has valid low and zero in all its fields.
- R7: Each MOP carries its instruction's arithmetic and address tags unchanged.
- R8: in_take equals the number of lanes consumed this clock, always lanes 0 to in_take-1. An instruction counts as consumed in the clock its first MOP enters a group. in_take is 0 whenever the output cannot advance.
- R9: While out_valid is high and out_ready is low, the output group stays unchanged on the next clock.
- R10: A clock with nothing to place yields out_valid low rather than an all-empty group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | LANES | Lane holds an instruction (contiguous from lane 0) |
| in_cls | input | 2*LANES | Class code per lane: 0 one, 1 two, 2 sequenced, 3 treated as one |
| in_cnt | input | CNT_W*LANES | MOP count per lane, used for class 2 only |
| in_alu | input | OP_W*LANES | Arithmetic-operation tag per lane |
| in_agu | input | OP_W*LANES | Address-request tag per lane |
| in_take | output | $clog2(LANES+1) | Number of lanes consumed this clock |
| out_valid | output | 1 | Output group holds at least one MOP |
| out_ready | input | 1 | Consumer accepts the group |
| out_slot_vld | output | SLOTS | Valid bit per slot |
| out_alu | output | OP_W*SLOTS | Arithmetic tag per slot |
| out_agu | output | OP_W*SLOTS | Address tag per slot |
| out_idx | output | CNT_W*SLOTS | MOP position inside its instruction |

## Verification
The assertions assume a well-behaved source. Valid lanes form a prefix from lane 0. After in_take lanes are consumed, the window shifts so that lane 0 holds the oldest unconsumed instruction. Sequenced counts stay between 3 and 15. The bench stimulus keeps within these limits because it drives the lanes from an in-order instruction queue at its head, truncated only to a random prefix length on starved clocks, and draws sequenced counts from that range. Backpressure is random, and a reset is applied in the middle of the run so that a partly issued instruction gets discarded.

// File: rtl/mop_pack_pkg.sv
package mop_pack_pkg;

  // Decode class of an incoming instruction
  typedef enum logic [1:0] {
    CLS_ONE = 2'd0,
    CLS_TWO = 2'd1,
    CLS_SEQ = 2'd2,
    CLS_RSV = 2'd3
  } mop_cls_e;

endpackage

// File: rtl/mop_lane_decode.sv
module mop_lane_decode
  import mop_pack_pkg::*;
#(
  parameter int LANES = 3,
  parameter int CNT_W = 4
) (
  input  logic [2*LANES-1:0]     cls_flat,
  input  logic [CNT_W*LANES-1:0] cnt_flat,
  output mop_cls_e               kind [LANES],
  output logic [CNT_W-1:0]       mops [LANES]
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mop_cls_e raw;
    assign raw = mop_cls_e'(cls_flat[2*g +: 2]);
    // reserved code folds onto the one-MOP path
    assign kind[g] = (raw == CLS_TWO || raw == CLS_SEQ) ? raw : CLS_ONE;
    assign mops[g] = (raw == CLS_SEQ) ? cnt_flat[g*CNT_W +: CNT_W] :
                     (raw == CLS_TWO) ? CNT_W'(2) : CNT_W'(1);
  end

endmodule

// File: rtl/mop_pack_core.sv
module mop_pack_core
  import mop_pack_pkg::*;
#(
  parameter int LANES = 3,
  parameter int SLOTS = 3,
  parameter int OP_W  = 8,
  parameter int CNT_W = 4,
  localparam int TAKE_W = $clog2(LANES+1)
) (
  input  logic [LANES-1:0]      lane_v,
  input  mop_cls_e              kind [LANES],
  input  logic [CNT_W-1:0]      mops [LANES],
  input  logic [OP_W*LANES-1:0] alu_flat,
  input  logic [OP_W*LANES-1:0] agu_flat,
  // carried-over instruction
  input  logic [CNT_W-1:0]      pend_left,
  input  logic [CNT_W-1:0]      pend_idx,
  input  logic [OP_W-1:0]       pend_alu,
  input  logic [OP_W-1:0]       pend_agu,
  input  logic                  pend_solo,
  // next group
  output logic [SLOTS-1:0]      slot_v,
  output logic [OP_W-1:0]       slot_alu [SLOTS],
  output logic [OP_W-1:0]       slot_agu [SLOTS],
  output logic [CNT_W-1:0]      slot_idx [SLOTS],
  output logic [TAKE_W-1:0]     take,
  // next carried-over state
  output logic [CNT_W-1:0]      nx_left,
  output logic [CNT_W-1:0]      nx_idx,
  output logic [OP_W-1:0]       nx_alu,
  output logic [OP_W-1:0]       nx_agu,
  output logic                  nx_solo
);

  always_comb begin
    int   p;
    int   c;
    logic stop;

    slot_v = '0;
    for (int s = 0; s < SLOTS; s++) begin
      slot_alu[s] = '0;
      slot_agu[s] = '0;
      slot_idx[s] = '0;
    end
    take    = '0;
    nx_left = pend_left;
    nx_idx  = pend_idx;
    nx_alu  = pend_alu;
    nx_agu  = pend_agu;
    nx_solo = pend_solo;
    p       = 0;
    stop    = 1'b0;

    // leftover MOPs of an earlier instruction come first
    if (pend_left != '0) begin
      c = (pend_left >= CNT_W'(SLOTS)) ? SLOTS : int'(pend_left);
      for (int s = 0; s < SLOTS; s++) begin
        if (s < c) begin
          slot_v[s]   = 1'b1;
          slot_alu[s] = pend_alu;
          slot_agu[s] = pend_agu;
          slot_idx[s] = pend_idx + CNT_W'(s);
        end
      end
      p       = c;
      nx_left = pend_left - CNT_W'(c);
      nx_idx  = pend_idx + CNT_W'(c);
      if (pend_solo || nx_left != '0) stop = 1'b1;
    end

    // then new lanes, strictly in order
    for (int i = 0; i < LANES; i++) begin
      c = 0;
      if (!stop && lane_v[i]) begin
        unique case (kind[i])
          CLS_TWO: begin
            if (p <= SLOTS-2) c = 2;
            else if (p < SLOTS) begin
              c       = 1;
              nx_left = CNT_W'(1);
              nx_idx  = CNT_W'(1);
              nx_alu  = alu_flat[i*OP_W +: OP_W];
              nx_agu  = agu_flat[i*OP_W +: OP_W];
              nx_solo = 1'b0;
              stop    = 1'b1;
            end else stop = 1'b1;
          end
          CLS_SEQ: begin
            if (p == 0) begin
              c       = (mops[i] >= CNT_W'(SLOTS)) ? SLOTS : int'(mops[i]);
              nx_left = mops[i] - CNT_W'(c);
              nx_idx  = CNT_W'(c);
              nx_alu  = alu_flat[i*OP_W +: OP_W];
              nx_agu  = agu_flat[i*OP_W +: OP_W];
              nx_solo = 1'b1;
            end
            stop = 1'b1;
          end
          default: begin
            if (p < SLOTS) c = 1;
            else stop = 1'b1;
          end
        endcase
      end
      if (c > 0) begin
        for (int s = 0; s < SLOTS; s++) begin
          if (s >= p && s < p + c) begin
            slot_v[s]   = 1'b1;
            slot_alu[s] = alu_flat[i*OP_W +: OP_W];
            slot_agu[s] = agu_flat[i*OP_W +: OP_W];
            slot_idx[s] = CNT_W'(s - p);
          end
        end
        p    = p + c;
        take = take + TAKE_W'(1);
      end
    end
  end

endmodule

// File: rtl/mop_group_reg.sv
module mop_group_reg #(
  parameter int SLOTS = 3,
  parameter int OP_W  = 8,
  parameter int CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv,
  input  logic [SLOTS-1:0]      d_v,
  input  logic [OP_W-1:0]       d_alu [SLOTS],
  input  logic [OP_W-1:0]       d_agu [SLOTS],
  input  logic [CNT_W-1:0]      d_idx [SLOTS],
  input  logic [CNT_W-1:0]      d_left,
  input  logic [CNT_W-1:0]      d_pidx,
  input  logic [OP_W-1:0]       d_palu,
  input  logic [OP_W-1:0]       d_pagu,
  input  logic                  d_solo,
  output logic                  q_valid,
  output logic [SLOTS-1:0]      q_v,
  output logic [OP_W*SLOTS-1:0] q_alu_flat,
  output logic [OP_W*SLOTS-1:0] q_agu_flat,
  output logic [CNT_W*SLOTS-1:0] q_idx_flat,
  output logic [CNT_W-1:0]      q_left,
  output logic [CNT_W-1:0]      q_pidx,
  output logic [OP_W-1:0]       q_palu,
  output logic [OP_W-1:0]       q_pagu,
  output logic                  q_solo
);

  logic [OP_W-1:0]  r_alu [SLOTS];
  logic [OP_W-1:0]  r_agu [SLOTS];
  logic [CNT_W-1:0] r_idx [SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_v     <= '0;
      q_left  <= '0;
      q_pidx  <= '0;
      q_palu  <= '0;
      q_pagu  <= '0;
      q_solo  <= 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
        r_alu[s] <= '0;
        r_agu[s] <= '0;
        r_idx[s] <= '0;
      end
    end else if (adv) begin
      q_valid <= |d_v;
      q_v     <= d_v;
      q_left  <= d_left;
      q_pidx  <= d_pidx;
      q_palu  <= d_palu;
      q_pagu  <= d_pagu;
      q_solo  <= d_solo;
      for (int s = 0; s < SLOTS; s++) begin
        r_alu[s] <= d_alu[s];
        r_agu[s] <= d_agu[s];
        r_idx[s] <= d_idx[s];
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_flat
    assign q_alu_flat[s*OP_W +: OP_W]   = r_alu[s];
    assign q_agu_flat[s*OP_W +: OP_W]   = r_agu[s];
    assign q_idx_flat[s*CNT_W +: CNT_W] = r_idx[s];
  end

endmodule

// File: rtl/mop_group_packer.sv
module mop_group_packer
  import mop_pack_pkg::*;
#(
  parameter int LANES = 3,
  parameter int SLOTS = 3,
  parameter int OP_W  = 8,
  parameter int CNT_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LANES-1:0]           in_valid,
  input  logic [2*LANES-1:0]         in_cls,
  input  logic [CNT_W*LANES-1:0]     in_cnt,
  input  logic [OP_W*LANES-1:0]      in_alu,
  input  logic [OP_W*LANES-1:0]      in_agu,
  output logic [$clog2(LANES+1)-1:0] in_take,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [SLOTS-1:0]           out_slot_vld,
  output logic [OP_W*SLOTS-1:0]      out_alu,
  output logic [OP_W*SLOTS-1:0]      out_agu,
  output logic [CNT_W*SLOTS-1:0]     out_idx
);

  localparam int TAKE_W = $clog2(LANES+1);

  mop_cls_e         kind [LANES];
  logic [CNT_W-1:0] mops [LANES];

  logic [SLOTS-1:0] nx_v;
  logic [OP_W-1:0]  nx_alu [SLOTS];
  logic [OP_W-1:0]  nx_agu [SLOTS];
  logic [CNT_W-1:0] nx_idx [SLOTS];
  logic [TAKE_W-1:0] take_raw;

  logic [CNT_W-1:0] p_left, p_idx, n_left, n_idx;
  logic [OP_W-1:0]  p_alu, p_agu, n_alu, n_agu;
  logic             p_solo, n_solo;
  logic             adv;

  assign adv     = !out_valid || out_ready;
  assign in_take = (adv && !rst) ? take_raw : '0;

  mop_lane_decode #(.LANES(LANES), .CNT_W(CNT_W)) u_dec (
    .cls_flat (in_cls),
    .cnt_flat (in_cnt),
    .kind     (kind),
    .mops     (mops)
  );

  mop_pack_core #(.LANES(LANES), .SLOTS(SLOTS), .OP_W(OP_W), .CNT_W(CNT_W)) u_core (
    .lane_v    (in_valid),
    .kind      (kind),
    .mops      (mops),
    .alu_flat  (in_alu),
    .agu_flat  (in_agu),
    .pend_left (p_left),
    .pend_idx  (p_idx),
    .pend_alu  (p_alu),
    .pend_agu  (p_agu),
    .pend_solo (p_solo),
    .slot_v    (nx_v),
    .slot_alu  (nx_alu),
    .slot_agu  (nx_agu),
    .slot_idx  (nx_idx),
    .take      (take_raw),
    .nx_left   (n_left),
    .nx_idx    (n_idx),
    .nx_alu    (n_alu),
    .nx_agu    (n_agu),
    .nx_solo   (n_solo)
  );

  mop_group_reg #(.SLOTS(SLOTS), .OP_W(OP_W), .CNT_W(CNT_W)) u_reg (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .d_v        (nx_v),
    .d_alu      (nx_alu),
    .d_agu      (nx_agu),
    .d_idx      (nx_idx),
    .d_left     (n_left),
    .d_pidx     (n_idx),
    .d_palu     (n_alu),
    .d_pagu     (n_agu),
    .d_solo     (n_solo),
    .q_valid    (out_valid),
    .q_v        (out_slot_vld),
    .q_alu_flat (out_alu),
    .q_agu_flat (out_agu),
    .q_idx_flat (out_idx),
    .q_left     (p_left),
    .q_pidx     (p_idx),
    .q_palu     (p_alu),
    .q_pagu     (p_agu),
    .q_solo     (p_solo)
  );

endmodule

// File: rtl/mop_group_packer_chk.sv
module mop_group_packer_chk #(
  parameter int LANES = 3,
  parameter int SLOTS = 3,
  parameter int OP_W  = 8,
  parameter int CNT_W = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic [LANES-1:0]           in_valid,
  input logic [$clog2(LANES+1)-1:0] in_take,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [SLOTS-1:0]           out_slot_vld,
  input logic [OP_W*SLOTS-1:0]      out_alu,
  input logic [OP_W*SLOTS-1:0]      out_agu,
  input logic [CNT_W*SLOTS-1:0]     out_idx
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && out_slot_vld == '0)); // R1

  AST_TAKE_IN_RESET: assert property (@(posedge clk)
    rst |-> in_take == '0); // R1

  AST_HOLD_GROUP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slot_vld) && $stable(out_alu)
                                   && $stable(out_agu) && $stable(out_idx))); // R9

  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> in_take == '0); // R8

  AST_TAKE_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(in_take) <= $countones(in_valid)); // R8

  AST_SLOT_PREFIX: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_slot_vld != '0 && (out_slot_vld & (out_slot_vld + SLOTS'(1))) == '0)); // R6

  AST_EMPTY_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_slot_vld == '0); // R10

  for (genvar s = 0; s < SLOTS; s++) begin : g_pad
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
      !out_slot_vld[s] |-> (out_alu[s*OP_W +: OP_W] == '0 && out_agu[s*OP_W +: OP_W] == '0
                            && out_idx[s*CNT_W +: CNT_W] == '0)); // R6
  end

endmodule

bind mop_group_packer mop_group_packer_chk #(
  .LANES(LANES), .SLOTS(SLOTS), .OP_W(OP_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_take      (in_take),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_slot_vld (out_slot_vld),
  .out_alu      (out_alu),
  .out_agu      (out_agu),
  .out_idx      (out_idx)
);

// File: tb/mop_group_packer_test.sv
module mop_group_packer_test;
  localparam int LANES  = 3;
  localparam int SLOTS  = 3;
  localparam int OP_W   = 8;
  localparam int CNT_W  = 4;
  localparam int TAKE_W = $clog2(LANES+1);
  localparam int NINST  = 1500;
  localparam int RST_AT = 400;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic                   rst;
  logic [LANES-1:0]       in_valid;
  logic [2*LANES-1:0]     in_cls;
  logic [CNT_W*LANES-1:0] in_cnt;
  logic [OP_W*LANES-1:0]  in_alu, in_agu;
  logic [TAKE_W-1:0]      in_take;
  logic                   out_valid, out_ready;
  logic [SLOTS-1:0]       out_slot_vld;
  logic [OP_W*SLOTS-1:0]  out_alu, out_agu;
  logic [CNT_W*SLOTS-1:0] out_idx;

  mop_group_packer #(.LANES(LANES), .SLOTS(SLOTS), .OP_W(OP_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls), .in_cnt(in_cnt),
    .in_alu(in_alu), .in_agu(in_agu), .in_take(in_take), .out_valid(out_valid),
    .out_ready(out_ready), .out_slot_vld(out_slot_vld), .out_alu(out_alu),
    .out_agu(out_agu), .out_idx(out_idx)
  );

  // instruction queue
  int q_cls [NINST];
  int q_cnt [NINST];
  int q_alu [NINST];
  int q_agu [NINST];
  int head;

  // lanes as driven
  bit lv [LANES];
  int lc [LANES], ln [LANES], la [LANES], lg [LANES];

  // reference state and expected group
  int m_left, m_idx, m_alu, m_agu;
  bit m_solo;
  int ek [SLOTS];   // 0 pad, 1 one-MOP, 2 two-MOP, 3 sequenced
  int ea [SLOTS], eg [SLOTS], ei [SLOTS];
  bit e_valid;
  int e_take;
  string tagm;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic put(int s, int k, int a, int g, int ix);
    ek[s] = k; ea[s] = a; eg[s] = g; ei[s] = ix;
  endtask

  task automatic model_clear();
    m_left = 0; m_idx = 0; m_alu = 0; m_agu = 0; m_solo = 0;
    for (int s = 0; s < SLOTS; s++) put(s, 0, 0, 0, 0);
    e_valid = 0;
    e_take  = 0;
  endtask

  // next group per the requirements, from bench state and driven lanes
  task automatic model_step();
    int p;
    int n;
    bit stop;
    for (int s = 0; s < SLOTS; s++) put(s, 0, 0, 0, 0);
    p = 0; stop = 0; e_take = 0;
    if (m_left > 0) begin
      n = (m_left < SLOTS) ? m_left : SLOTS;
      for (int s = 0; s < n; s++) put(s, m_solo ? 3 : 2, m_alu, m_agu, m_idx + s);
      p = n; m_left -= n; m_idx += n;
      if (m_solo || m_left > 0) stop = 1;
    end
    for (int i = 0; i < LANES; i++) begin
      if (!stop && lv[i]) begin
        if (lc[i] == 1) begin
          if (p + 2 <= SLOTS) begin
            put(p, 2, la[i], lg[i], 0); put(p+1, 2, la[i], lg[i], 1);
            p += 2; e_take++;
          end else if (p < SLOTS) begin
            put(p, 2, la[i], lg[i], 0);
            m_left = 1; m_idx = 1; m_alu = la[i]; m_agu = lg[i]; m_solo = 0;
            p = SLOTS; e_take++; stop = 1;
          end else stop = 1;
        end else if (lc[i] == 2) begin
          if (p == 0) begin
            n = (ln[i] < SLOTS) ? ln[i] : SLOTS;
            for (int s = 0; s < n; s++) put(s, 3, la[i], lg[i], s);
            m_left = ln[i] - n; m_idx = n; m_alu = la[i]; m_agu = lg[i]; m_solo = 1;
            p = n; e_take++;
          end
          stop = 1;
        end else begin
          if (p < SLOTS) begin
            put(p, 1, la[i], lg[i], 0); p++; e_take++;
          end else stop = 1;
        end
      end
    end
    e_valid = (p > 0);
  endtask

  function automatic string kind_tag(int k);
    case (k)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic compare();
    string kt, pt;
    chk(out_valid == e_valid, (tagm != "") ? tagm : "R10", "out_valid", out_valid, e_valid);
    for (int s = 0; s < SLOTS; s++) begin
      kt = (tagm != "") ? tagm : kind_tag(ek[s]);
      pt = (tagm != "") ? tagm : ((ek[s] != 0) ? "R5/R7" : "R6");
      chk(out_slot_vld[s] == (ek[s] != 0), kt, $sformatf("slot%0d valid", s),
          out_slot_vld[s], (ek[s] != 0));
      chk(int'(out_idx[s*CNT_W +: CNT_W]) == ei[s], kt, $sformatf("slot%0d idx", s),
          out_idx[s*CNT_W +: CNT_W], ei[s]);
      chk(int'(out_alu[s*OP_W +: OP_W]) == ea[s], pt, $sformatf("slot%0d alu", s),
          out_alu[s*OP_W +: OP_W], ea[s]);
      chk(int'(out_agu[s*OP_W +: OP_W]) == eg[s], pt, $sformatf("slot%0d agu", s),
          out_agu[s*OP_W +: OP_W], eg[s]);
    end
  endtask

  task automatic set_inst(int k, int c, int n);
    q_cls[k] = c;
    q_cnt[k] = n;
    q_alu[k] = (k * 7 + 1) % 256;
    q_agu[k] = $urandom % 256;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    int r;
    int vcnt;
    void'($urandom(32'd7321));
    // directed prefix
    set_inst(0, 1, 0); set_inst(1, 1, 0); set_inst(2, 1, 0);    // R3 three doubles
    set_inst(3, 0, 0); set_inst(4, 0, 0); set_inst(5, 0, 0);    // R2 three singles
    set_inst(6, 1, 0); set_inst(7, 0, 0);                       // double + single
    set_inst(8, 2, 7);                                          // R4 spans three groups
    set_inst(9, 0, 0); set_inst(10, 2, 3); set_inst(11, 0, 0);  // R5 single waits
    set_inst(12, 2, 15);
    set_inst(13, 3, 0);                                         // R2 reserved code
    set_inst(14, 1, 0); set_inst(15, 1, 0); set_inst(16, 2, 4);
    set_inst(17, 0, 0);
    for (int k = 18; k < NINST; k++) begin
      r = $urandom % 8;
      if (r < 4)       set_inst(k, 0, 0);
      else if (r < 6)  set_inst(k, 1, 0);
      else if (r == 6) set_inst(k, 2, 3 + $urandom % 13);
      else             set_inst(k, 3, 0);
    end

    rst = 1; out_ready = 0; in_valid = '0; in_cls = '0; in_cnt = '0; in_alu = '0; in_agu = '0;
    head = 0; tagm = "R1";
    model_clear();

    for (int cyc = 0; ; cyc++) begin
      @(negedge clk);
      if (cyc > 0) compare();
      head += e_take;
      if (cyc > RST_AT + 5 && head >= NINST && m_left == 0 && !e_valid) break;

      rst = (cyc < 3) || (cyc >= RST_AT && cyc < RST_AT + 2);
      out_ready = (cyc < 60) ? 1'b1 : (($urandom % 4) != 0);
      vcnt = LANES;
      if (cyc >= 60 && ($urandom % 8) == 0) vcnt = $urandom % LANES;
      for (int i = 0; i < LANES; i++) begin
        lv[i] = (i < vcnt) && (head + i < NINST);
        lc[i] = lv[i] ? q_cls[head+i] : 0;
        ln[i] = lv[i] ? q_cnt[head+i] : 0;
        la[i] = lv[i] ? q_alu[head+i] : 0;
        lg[i] = lv[i] ? q_agu[head+i] : 0;
        in_valid[i]             = lv[i];
        in_cls[2*i +: 2]        = 2'(lc[i]);
        in_cnt[i*CNT_W +: CNT_W] = CNT_W'(ln[i]);
        in_alu[i*OP_W +: OP_W]  = OP_W'(la[i]);
        in_agu[i*OP_W +: OP_W]  = OP_W'(lg[i]);
      end

      #9;
      if (rst) begin
        chk(in_take == '0, "R1", "in_take in reset", in_take, 0);
        model_clear();
        tagm = "R1";
      end else if (!e_valid || out_ready) begin
        model_step();
        chk(int'(in_take) == e_take, "R8", "in_take", in_take, e_take);
        tagm = "";
      end else begin
        chk(in_take == '0, "R8", "in_take while held", in_take, 0);
        e_take = 0;
        tagm = "R9";
      end
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule